// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block is a passive observer placed beside a single-data-rate SDRAM command bus. On every rising clock edge it samples the clock enable, the four command strobes, the bank select and the address. It turns them into a command, keeps a model of which banks hold an open row, and measures in clock cycles how far each command sits from the earlier commands it depends on. All minimum distances are parameters given in cycles, so one netlist serves any speed grade once the nanosecond figures are rounded up to whole clocks.

Each spacing or precondition rule owns one bit of an error vector. That bit pulses for one cycle when a command breaks the rule. A single sticky flag collects every pulse until a synchronous clear. The monitor never drives the bus. Commands that break a rule still update its model of the banks, so that it keeps tracking the device after a fault.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: An activate to a bank other than the most recently activated one, fewer than T_RRD cycles after that activate, sets rule_err[0].
- R2: A read or write to an open bank fewer than T_RCD cycles after that bank's activate sets rule_err[1].
- R3: A precharge that closes an open bank (single, or all banks when addr[10] is 1) sets rule_err[2] if the bank has been open fewer than T_RAS cycles or more than T_RAS_MAX cycles.
- R4: An activate to a closed bank fewer than T_RP cycles after that bank closed sets rule_err[3]. Closing is either an explicit precharge or the end of an auto-precharge burst.
- R5: An activate fewer than T_RC cycles after the previous activate to the same bank sets rule_err[4].
- R6: A precharge to a bank sets rule_err[5] while a write burst to it is still running, or fewer than T_WR cycles after its last write beat. The last beat falls at the write cycle plus burst length minus one.
- R7: Any command other than NOP or deselect fewer than T_MRD cycles after a mode register set sets rule_err[6]. The mode register set loads the burst length from addr[2:0]: 0, 1, 2, 3 and 7 give 1, 2, 4, 8 and PAGE_LEN beats, and any other code gives 1.
- R8: rule_err[7] flags state faults: an activate to an open bank; a read or write to a closed bank; a mode register set or refresh while any bank is open. Commands are decoded from {cs_n,ras_n,cas_n,we_n} as follows: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode register set 0000, NOP 0111. Any code with cs_n high is a deselect.
- R9: A read or write with addr[10] high runs in auto-precharge mode. A read or write to that bank before its last beat sets rule_err[7]. The bank closes at the last beat, and R4 then applies from that cycle.
- R10: A command is accepted only when cke is high in both the current and the previous cycle. A non-NOP command in the first cycle of high cke after a low one sets rule_err[8] and has no other effect. Commands while cke is low are ignored.
- R11: Error bits are registered. They are visible for exactly one cycle, after the edge that samples the offending command. All of them are zero after reset and after any NOP or deselect.
- R12: sticky_err becomes the OR of its previous value and all error bits. With clr_sticky high the previous value is dropped, but an error in the same cycle still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Multiplexed address; bit AP_BIT selects auto-precharge or all banks |
| clr_sticky | input | 1 | Synchronous clear of the sticky flag |
| rule_err | output | 9 | One-cycle error pulse per rule |
| sticky_err | output | 1 | Accumulated error flag |

## Verification
The stream first places each spacing rule one cycle short of its minimum, and then again exactly at the minimum. This separates an off-by-one in the age counters from a correct bound. Precharge-all with a mix of young and old open banks shows whether the row-active check is applied per bank. Auto-precharge bursts show whether the closing point is placed at the last beat and not at the command. A write followed by a precharge two cycles later, under burst lengths 4 and 1, shows whether the mode register actually steers the write-recovery window. Clock-enable toggling and clears coinciding with errors separate ignored commands from commands that were rejected.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_BST,
      CMD_PRE,
      CMD_REF,
      CMD_MRS
   } cmd_e;

   localparam int RULE_RRD   = 0;
   localparam int RULE_RCD   = 1;
   localparam int RULE_RAS   = 2;
   localparam int RULE_RP    = 3;
   localparam int RULE_RC    = 4;
   localparam int RULE_WR    = 5;
   localparam int RULE_MRD   = 6;
   localparam int RULE_STATE = 7;
   localparam int RULE_CKE   = 8;
   localparam int NUM_RULES  = 9;

   // Strobe decode; a high chip select reads as no command.
   function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
      cmd_e c;
      if (cs_n) c = CMD_NOP;
      else begin
         case ({ras_n, cas_n, we_n})
            3'b011:  c = CMD_ACT;
            3'b101:  c = CMD_RD;
            3'b100:  c = CMD_WR;
            3'b110:  c = CMD_BST;
            3'b010:  c = CMD_PRE;
            3'b001:  c = CMD_REF;
            3'b000:  c = CMD_MRS;
            default: c = CMD_NOP;
         endcase
      end
      return c;
   endfunction

   // Burst length code of the mode register (R7).
   function automatic int unsigned burst_beats(input logic [2:0] code,
                                               input int unsigned page_len);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         3'd7:    return page_len;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd,
   output logic cke_err
);

   cmd_e raw;
   logic cke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= 1'b0;
      else        cke_q <= cke;
   end

   always_comb begin
      raw     = decode_cmd(cs_n, ras_n, cas_n, we_n);
      // R10: accepted only after a full cycle of high clock enable
      cmd     = (cke && cke_q) ? raw : CMD_NOP;
      cke_err = cke && !cke_q && (raw != CMD_NOP);
   end

endmodule

// File: rtl/sdram_bus_track.sv
module sdram_bus_track
   import sdram_mon_pkg::*;
#(
   parameter int BA_W     = 2,
   parameter int T_RRD    = 2,
   parameter int T_MRD    = 2,
   parameter int PAGE_LEN = 512,
   parameter int FIXED_BL = 0,
   localparam int BLW     = $clog2(PAGE_LEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cmd_e            cmd,
   input  logic [BA_W-1:0] ba,
   input  logic [2:0]      mode_code,
   output logic            rrd_v,
   output logic            mrd_v,
   output logic [BLW-1:0]  bl
);

   localparam int RW = $clog2(T_RRD + 2);
   localparam int MW = $clog2(T_MRD + 2);
   localparam logic [RW-1:0] RSAT = RW'(T_RRD + 1);
   localparam logic [MW-1:0] MSAT = MW'(T_MRD + 1);
   localparam logic [RW-1:0] RRD_C = RW'(T_RRD);
   localparam logic [MW-1:0] MRD_C = MW'(T_MRD);

   logic [RW-1:0]   rrd_age;
   logic [MW-1:0]   mrs_age;
   logic [BA_W-1:0] last_bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rrd_age   <= RSAT;
         mrs_age   <= MSAT;
         last_bank <= '0;
      end else begin
         rrd_age <= (rrd_age == RSAT) ? rrd_age : rrd_age + 1'b1;
         mrs_age <= (mrs_age == MSAT) ? mrs_age : mrs_age + 1'b1;
         if (cmd == CMD_ACT) begin
            rrd_age   <= RW'(1);
            last_bank <= ba;
         end
         if (cmd == CMD_MRS) mrs_age <= MW'(1);
      end
   end

   // R1 and R7 spacing
   assign rrd_v = (cmd == CMD_ACT) && (ba != last_bank) && (rrd_age < RRD_C);
   assign mrd_v = (cmd != CMD_NOP) && (mrs_age < MRD_C);

   generate
      if (FIXED_BL != 0) begin : g_fixed_bl
         logic unused_code;
         assign unused_code = ^mode_code;
         assign bl = BLW'(FIXED_BL);
      end else begin : g_mode_bl
         logic [BLW-1:0] bl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               bl_q <= BLW'(1);
            else if (cmd == CMD_MRS)  bl_q <= BLW'(burst_beats(mode_code, PAGE_LEN));
         end
         assign bl = bl_q;
      end
   endgenerate

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_mon_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_RC      = 9,
   parameter int T_WR      = 2,
   parameter int T_RAS_MAX = 13300,
   parameter int BLW       = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  cmd_e           cmd,
   input  logic           hit,
   input  logic           pre_all,
   input  logic           ap,
   input  logic [BLW-1:0] bl,
   output logic           is_open,
   output logic           rcd_v,
   output logic           ras_v,
   output logic           rp_v,
   output logic           rc_v,
   output logic           wr_v,
   output logic           state_v
);

   localparam int CW = $clog2(T_RAS_MAX + 2);
   localparam logic [CW-1:0] SAT    = CW'(T_RAS_MAX + 1);
   localparam logic [CW-1:0] RCD_C  = CW'(T_RCD);
   localparam logic [CW-1:0] RP_C   = CW'(T_RP);
   localparam logic [CW-1:0] RAS_C  = CW'(T_RAS);
   localparam logic [CW-1:0] RASX_C = CW'(T_RAS_MAX);
   localparam logic [CW-1:0] RC_C   = CW'(T_RC);
   localparam logic [CW-1:0] WR_C   = CW'(T_WR);

   logic           open_q;
   logic [CW-1:0]  act_age, pre_age, wr_age;
   logic [BLW-1:0] wr_left, ap_left;
   logic           is_col, do_act, do_pre, do_col;

   always_comb begin
      is_col = (cmd == CMD_RD || cmd == CMD_WR) && hit;
      do_act = (cmd == CMD_ACT) && hit;
      do_pre = (cmd == CMD_PRE) && (hit || pre_all) && open_q;
      do_col = is_col && open_q && (ap_left == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         act_age <= SAT;
         pre_age <= SAT;
         wr_age  <= SAT;
         wr_left <= '0;
         ap_left <= '0;
      end else begin
         act_age <= (act_age == SAT) ? act_age : act_age + 1'b1;
         pre_age <= (pre_age == SAT) ? pre_age : pre_age + 1'b1;
         wr_age  <= (wr_age  == SAT) ? wr_age  : wr_age  + 1'b1;
         // write beats count down to the last one (R6)
         if (wr_left != '0) begin
            wr_left <= wr_left - 1'b1;
            if (wr_left == BLW'(1)) wr_age <= CW'(1);
         end
         // auto-precharge closes the bank at its last beat (R9)
         if (ap_left != '0) begin
            ap_left <= ap_left - 1'b1;
            if (ap_left == BLW'(1)) begin
               open_q  <= 1'b0;
               pre_age <= CW'(1);
            end
         end
         if (do_act) begin
            open_q  <= 1'b1;
            act_age <= CW'(1);
         end
         if (do_pre) begin
            open_q  <= 1'b0;
            pre_age <= CW'(1);
            wr_left <= '0;
            ap_left <= '0;
         end
         if (do_col) begin
            if (cmd == CMD_WR) begin
               if (bl == BLW'(1)) wr_age  <= CW'(1);
               else               wr_left <= bl - 1'b1;
            end
            if (ap) begin
               if (bl == BLW'(1)) begin
                  open_q  <= 1'b0;
                  pre_age <= CW'(1);
               end else begin
                  ap_left <= bl - 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      is_open = open_q;
      rcd_v   = is_col && open_q && (act_age < RCD_C);                          // R2
      ras_v   = do_pre && ((act_age < RAS_C) || (act_age > RASX_C));            // R3
      rp_v    = do_act && !open_q && (pre_age < RP_C);                          // R4
      rc_v    = do_act && (act_age < RC_C);                                     // R5
      wr_v    = do_pre && ((wr_left != '0) || (wr_age < WR_C));                 // R6
      state_v = (do_act && open_q) || (is_col && (!open_q || ap_left != '0));   // R8 R9
   end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   parameter int T_RRD     = 2,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_RC      = 9,
   parameter int T_WR      = 2,
   parameter int T_MRD     = 2,
   parameter int T_RAS_MAX = 13300,
   parameter int PAGE_LEN  = 512,
   parameter int FIXED_BL  = 0,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int BLW      = $clog2(PAGE_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 clr_sticky,
   output logic [NUM_RULES-1:0] rule_err,
   output logic                 sticky_err
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (AP_BIT >= ADDR_W || ADDR_W < 3) begin : g_bad_addr
         $error("AP_BIT must lie inside the address and ADDR_W be at least 3");
      end
      if (T_RRD < 1 || T_RCD < 1 || T_RP < 1 || T_RAS < 1 || T_RC < 1 ||
          T_WR < 1 || T_MRD < 1) begin : g_bad_timing
         $error("timing minimums must be at least one cycle");
      end
      if (T_RAS_MAX < T_RAS || T_RAS_MAX < T_RC) begin : g_bad_rasmax
         $error("T_RAS_MAX must cover T_RAS and T_RC");
      end
      if (PAGE_LEN < 8 || FIXED_BL < 0 || FIXED_BL > PAGE_LEN) begin : g_bad_bl
         $error("PAGE_LEN must be at least 8 and FIXED_BL within it");
      end
   endgenerate

   cmd_e           cmd;
   logic           cke_err;
   logic           rrd_v, mrd_v;
   logic [BLW-1:0] bl;
   logic [NUM_BANKS-1:0] open_vec, rcd_vec, ras_vec, rp_vec, rc_vec, wr_vec, st_vec;
   logic [NUM_RULES-1:0] err;
   logic           unused_addr;

   assign unused_addr = ^addr;

   sdram_cmd_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .cke    (cke),
      .cs_n   (cs_n),
      .ras_n  (ras_n),
      .cas_n  (cas_n),
      .we_n   (we_n),
      .cmd    (cmd),
      .cke_err(cke_err)
   );

   sdram_bus_track #(
      .BA_W    (BA_W),
      .T_RRD   (T_RRD),
      .T_MRD   (T_MRD),
      .PAGE_LEN(PAGE_LEN),
      .FIXED_BL(FIXED_BL)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .ba       (ba),
      .mode_code(addr[2:0]),
      .rrd_v    (rrd_v),
      .mrd_v    (mrd_v),
      .bl       (bl)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      sdram_bank_track #(
         .T_RCD    (T_RCD),
         .T_RP     (T_RP),
         .T_RAS    (T_RAS),
         .T_RC     (T_RC),
         .T_WR     (T_WR),
         .T_RAS_MAX(T_RAS_MAX),
         .BLW      (BLW)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .cmd    (cmd),
         .hit    (ba == BA_W'(g)),
         .pre_all(addr[AP_BIT]),
         .ap     (addr[AP_BIT]),
         .bl     (bl),
         .is_open(open_vec[g]),
         .rcd_v  (rcd_vec[g]),
         .ras_v  (ras_vec[g]),
         .rp_v   (rp_vec[g]),
         .rc_v   (rc_vec[g]),
         .wr_v   (wr_vec[g]),
         .state_v(st_vec[g])
      );
   end

   always_comb begin
      err             = '0;
      err[RULE_RRD]   = rrd_v;
      err[RULE_RCD]   = |rcd_vec;
      err[RULE_RAS]   = |ras_vec;
      err[RULE_RP]    = |rp_vec;
      err[RULE_RC]    = |rc_vec;
      err[RULE_WR]    = |wr_vec;
      err[RULE_MRD]   = mrd_v;
      // R8: mode set and refresh need every bank closed
      err[RULE_STATE] = (|st_vec) ||
                        (((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_vec));
      err[RULE_CKE]   = cke_err;
   end

   // R11 registered pulses, R12 sticky accumulation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rule_err   <= '0;
         sticky_err <= 1'b0;
      end else begin
         rule_err   <= err;
         sticky_err <= (sticky_err && !clr_sticky) || (|err);
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
   parameter int NR = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cke,
   input logic          cs_n,
   input logic          ras_n,
   input logic          cas_n,
   input logic          we_n,
   input logic          clr_sticky,
   input logic [NR-1:0] rule_err,
   input logic          sticky_err
);

   AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || (ras_n && cas_n && we_n)) |=> (rule_err == '0)); // R11

   AST_CKE_LOW_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> (rule_err == '0)); // R10

   AST_STICKY_SEES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (|rule_err) |-> sticky_err); // R12

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_err && !clr_sticky) |=> sticky_err); // R12

   AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sticky |=> (sticky_err == (|rule_err))); // R12

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NR(sdram_mon_pkg::NUM_RULES)) u_chk (.*);

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;

   localparam int NR = 9;
   localparam logic [NR-1:0] E_RRD = 9'h001, E_RCD = 9'h002, E_RAS = 9'h004,
                             E_RP = 9'h008, E_RC = 9'h010, E_WR = 9'h020,
                             E_MRD = 9'h040, E_ST = 9'h080, E_CKE = 9'h100;
   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                          C_MRS = 4'b0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic [11:0] addr = '0;
   logic clr_sticky = 1'b0;
   logic [NR-1:0] rule_err;
   logic sticky_err;

   always #10 clk = ~clk;

   sdram_cmd_monitor #(.T_RAS_MAX(40), .PAGE_LEN(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .clr_sticky(clr_sticky), .rule_err(rule_err), .sticky_err(sticky_err)
   );

   typedef struct {
      logic [NR-1:0] exp;
      logic          clr;
      string         tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   logic model_sticky = 1'b0;
   logic cke_drv = 1'b1;
   logic done = 1'b0;

   task automatic cyc(input logic [3:0] c, input int b, input logic [11:0] a,
                      input logic [NR-1:0] exp, input logic clr, input string tag);
      item_t it;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b[1:0];
      addr = a;
      clr_sticky = clr;
      cke = cke_drv;
      it.exp = exp; it.clr = clr; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) cyc(C_NOP, 0, 12'h000, '0, 1'b0, "R11");
   endtask
   task automatic act(input int b, input logic [NR-1:0] e, input string t);
      cyc(C_ACT, b, 12'h000, e, 1'b0, t);
   endtask
   task automatic rd(input int b, input logic ap, input logic [NR-1:0] e, input string t);
      cyc(C_RD, b, ap ? 12'h400 : 12'h000, e, 1'b0, t);
   endtask
   task automatic wr(input int b, input logic ap, input logic [NR-1:0] e, input string t);
      cyc(C_WR, b, ap ? 12'h400 : 12'h000, e, 1'b0, t);
   endtask
   task automatic pre(input int b, input logic all, input logic [NR-1:0] e, input string t);
      cyc(C_PRE, b, all ? 12'h400 : 12'h000, e, 1'b0, t);
   endtask
   task automatic mrs(input logic [2:0] code, input logic [NR-1:0] e, input string t);
      cyc(C_MRS, 0, {9'd0, code}, e, 1'b0, t);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // monitor: one expected item per clock edge
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            it = q.pop_front();
            model_sticky = (it.clr ? 1'b0 : model_sticky) | (|it.exp);
            checks++;
            if (rule_err !== it.exp) begin
               errors++;
               $display("FAIL %s rule_err actual=%b expected=%b", it.tag, rule_err, it.exp);
            end
            checks++;
            if (sticky_err !== model_sticky) begin
               errors++;
               $display("FAIL R12 (%s) sticky_err actual=%b expected=%b",
                        it.tag, sticky_err, model_sticky);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rule_err !== '0 || sticky_err !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset state actual=%b/%b expected=0/0", rule_err, sticky_err);
      end
      rst_n = 1'b1;
      nop(2);
      // timing segment
      mrs(3'd2, '0, "R7");
      act(0, E_MRD, "R7");
      rd(0, 1'b0, E_RCD, "R2");
      nop(1);
      rd(0, 1'b0, '0, "R2");
      act(1, '0, "R1");
      act(2, E_RRD, "R1");
      nop(1);
      act(3, '0, "R1");
      pre(1, 1'b0, E_RAS, "R3");
      act(1, E_RP | E_RC, "R4 R5");
      pre(0, 1'b0, '0, "R3");
      nop(2);
      act(0, '0, "R4");
      nop(1);
      act(2, E_ST, "R8");
      pre(0, 1'b1, E_RAS, "R3");
      rd(1, 1'b0, E_ST, "R8");
      cyc(C_REF, 0, 12'h000, '0, 1'b0, "R8");
      nop(10);
      // write recovery with burst length 4
      act(0, '0, "R6");
      nop(2);
      wr(0, 1'b0, '0, "R6");
      nop(3);
      pre(0, 1'b0, E_WR, "R6");
      nop(3);
      act(0, '0, "R6");
      nop(2);
      wr(0, 1'b0, '0, "R6");
      nop(4);
      pre(0, 1'b0, '0, "R6");
      nop(3);
      // auto-precharge burst
      act(0, '0, "R9");
      nop(5);
      rd(0, 1'b1, '0, "R9");
      wr(0, 1'b0, E_ST, "R9");
      nop(2);
      act(0, E_RP, "R9");
      nop(6);
      pre(0, 1'b1, '0, "R3");
      nop(3);
      // mode set with an open bank
      act(3, '0, "R8");
      mrs(3'd2, E_ST, "R8");
      nop(5);
      pre(3, 1'b0, '0, "R3");
      nop(4);
      // burst length 1 shortens write recovery
      mrs(3'd0, '0, "R7");
      nop(1);
      act(1, '0, "R7");
      nop(3);
      wr(1, 1'b0, '0, "R7");
      nop(1);
      pre(1, 1'b0, '0, "R7");
      nop(3);
      // clock enable lead
      cke_drv = 1'b0;
      act(2, '0, "R10");
      cke_drv = 1'b1;
      act(2, E_CKE, "R10");
      act(2, '0, "R10");
      nop(6);
      pre(2, 1'b0, '0, "R10");
      nop(2);
      // sticky clear
      cyc(C_NOP, 0, 12'h000, '0, 1'b1, "R12");
      nop(1);
      cyc(C_RD, 0, 12'h000, E_ST, 1'b1, "R12");
      nop(2);
      // row open too long
      act(0, '0, "R3");
      nop(40);
      pre(0, 1'b0, E_RAS, "R3");
      nop(3);
      repeat (2) @(posedge clk);
      #6;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule